// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit watches one external capture pin and, when a qualifying event occurs, stores a timestamp from one of two free-running timers. The timers run in the system clock domain outside the unit and arrive as plain 16-bit inputs. A select input picks timer A or timer B. A 4-bit mode field picks the event: each falling edge, each rising edge, every fourth rising edge or every sixteenth rising edge. Any other code turns capture off.

The pin is asynchronous. It passes through a synchronizer chain and an edge detector. In the divided modes a rising-edge counter gates the events. Each capture loads the timer value into the capture register and raises an interrupt flag. The flag stays set until software pulses a clear input.

A capture that arrives before software has read the register overwrites the old value. No loss indication exists. Moving straight from one active mode to another does not reset the edge counter, and it raises the flag as a false event. Software avoids both effects by passing through the off code.

The capture value is a plain level output, not a stream. It has no valid/ready handshake and no back-pressure: a newer capture always replaces the held value, and the flag is the only signal that new data is present.

Top module: `tcap_top`

## Requirements
- R1: After reset the capture value is 0, the flag is clear and the edge counter is empty.
- R2: In mode 4'b0100 each falling edge of the pin captures, and rising edges do not.
- R3: In mode 4'b0101 each rising edge of the pin captures, and falling edges do not.
- R4: In mode 4'b0110, starting from an empty counter, only the 4th rising edge captures. Edges 1 to 3 leave the value and the flag unchanged.
- R5: In mode 4'b0111, starting from an empty counter, only the 16th rising edge captures. Edges 1 to 15 leave the value and the flag unchanged.
- R6: With src_sel 0 the capture takes timer_a. With src_sel 1 it takes timer_b.
- R7: The flag stays set until a one-cycle flag_clr pulse, which clears it.
- R8: When a capture and flag_clr fall in the same cycle, the flag ends up set.
- R9: A capture made while the flag is still set overwrites the value, and every change of the capture value comes with the flag set.
- R10: Mode 4'b0000, and every code outside 4'b0100 to 4'b0111, makes no captures and empties the edge counter.
- R11: Moving from mode 4'b0111 to mode 4'b0110 without passing through off keeps the edge count. After 5 counted edges, the next rising edge captures.
- R12: A change from one active mode to a different active mode sets the flag one clock later, with no pin activity. A change from off to an active mode does not set it.
- R13: A pin transition that is stable before clock edge 1 is captured at clock edge 3. The value and the flag are still unchanged after clock edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 4 | Capture mode code |
| src_sel | input | 1 | Timer source select: 0 = timer A, 1 = timer B |
| timer_a | input | 16 | Timer A count |
| timer_b | input | 16 | Timer B count |
| cap_pin | input | 1 | Asynchronous capture pin |
| flag_clr | input | 1 | Software clear strobe for the flag |
| cap_val | output | 16 | Captured timer value |
| cap_flag | output | 1 | Capture interrupt flag |

## Verification
A qualified capture and the software clear strobe can land in the same clock cycle and act on the same flag. The bench provokes this by counting the synchronizer latency from the pin transition and raising flag_clr for exactly the cycle that ends at the capturing clock edge. The result is correct only if the flag is set afterwards and the new timer value is in the register.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam logic [3:0] MODE_OFF   = 4'b0000;
  localparam logic [3:0] MODE_FALL  = 4'b0100;
  localparam logic [3:0] MODE_RISE  = 4'b0101;
  localparam logic [3:0] MODE_DIVLO = 4'b0110;
  localparam logic [3:0] MODE_DIVHI = 4'b0111;

  function automatic logic mode_active(input logic [3:0] m);
    return (m[3:2] == 2'b01);
  endfunction
endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin_async};
  end

  always_comb begin
    rise = chain[STAGES-1] & ~chain[STAGES];
    fall = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale
  import tcap_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       rise,
  input  logic       fall,
  output logic       evt,
  output logic       mode_hop
);
  localparam int CNT_W = $clog2(DIV_HI);
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(DIV_HI - 1);

  logic [CNT_W-1:0] cnt;
  logic [3:0]       prev_mode;
  logic             divided;

  always_comb begin
    divided = (mode == MODE_DIVLO) || (mode == MODE_DIVHI);
    unique case (mode)
      MODE_FALL:  evt = fall;
      MODE_RISE:  evt = rise;
      MODE_DIVLO: evt = rise && (cnt >= LIM_LO);
      MODE_DIVHI: evt = rise && (cnt >= LIM_HI);
      default:    evt = 1'b0;
    endcase
    mode_hop = mode_active(mode) && mode_active(prev_mode) && (mode != prev_mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev_mode <= MODE_OFF;
    end else begin
      prev_mode <= mode;
      if (!mode_active(mode))   cnt <= '0;
      else if (divided && rise) cnt <= evt ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_sel,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          evt,
  input  logic          mode_hop,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag
);
  logic [TW-1:0] src;

  always_comb src = src_sel ? timer_b : timer_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
    end else begin
      if (evt) cap_val <= src;
      cap_flag <= evt | mode_hop | (cap_flag & ~flag_clr);
    end
  end
endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
  parameter int TW     = 16,
  parameter int STAGES = 2,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_mode,
  input  logic          src_sel,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          cap_pin,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag
);
  logic rise_w, fall_w, evt_w, hop_w;

  tcap_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(cap_pin), .rise(rise_w), .fall(fall_w)
  );

  tcap_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_ps (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .rise(rise_w), .fall(fall_w),
    .evt(evt_w), .mode_hop(hop_w)
  );

  tcap_capture #(.TW(TW)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .timer_a(timer_a), .timer_b(timer_b),
    .evt(evt_w), .mode_hop(hop_w), .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag)
  );
endmodule

// File: rtl/tcap_checks.sv
module tcap_checks #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cfg_mode,
  input logic          flag_clr,
  input logic [TW-1:0] cap_val,
  input logic          cap_flag,
  input logic          cap_evt
);
  // R7: a set flag without a clear stays set
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R8: a qualified event always leaves the flag set, clear or not
  a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

  // R10: off mode never alters the capture value
  a_r10_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 4'b0000) |=> $stable(cap_val));

  // R9: any change of the held value comes with the flag set
  a_r9_new_value_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_val) |-> cap_flag);
endmodule

bind tcap_top tcap_checks #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .flag_clr(flag_clr),
  .cap_val(cap_val), .cap_flag(cap_flag), .cap_evt(evt_w)
);

// File: tb/tb_tcap_top.sv
module tb_tcap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_mode = 4'b0000;
  logic        src_sel = 1'b0;
  logic [15:0] timer_a = 16'h0000;
  logic [15:0] timer_b = 16'h0000;
  logic        cap_pin = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tcap_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .src_sel(src_sel),
    .timer_a(timer_a), .timer_b(timer_b), .cap_pin(cap_pin), .flag_clr(flag_clr),
    .cap_val(cap_val), .cap_flag(cap_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling clock edge.
  task automatic drive_pin(input logic v);
    cap_pin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    drive_pin(1'b1);
    drive_pin(1'b0);
  endtask

  task automatic set_mode(input logic [3:0] m);
    cfg_mode = m;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 value", cap_val, 16'h0);
    check("R1 flag", cap_flag, 1'b0);
  endtask

  task automatic t_rise_latency();
    set_mode(4'b0101);
    check("R12 off->active no flag", cap_flag, 1'b0);
    timer_a = 16'h1234;
    cap_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R13 flag after edge 2", cap_flag, 1'b0);
    check("R13 value after edge 2", cap_val, 16'h0);
    @(negedge clk);
    check("R13 flag after edge 3", cap_flag, 1'b1);
    check("R3 rise value", cap_val, 16'h1234);
    clear_flag();
    timer_a = 16'h5555;
    drive_pin(1'b0);
    check("R3 fall ignored value", cap_val, 16'h1234);
    check("R3 fall ignored flag", cap_flag, 1'b0);
  endtask

  task automatic t_fall();
    set_mode(4'b0000);
    set_mode(4'b0100);
    check("R12 via off no flag", cap_flag, 1'b0);
    timer_a = 16'h0A0A;
    drive_pin(1'b1);
    check("R2 rise ignored", cap_val, 16'h1234);
    check("R2 rise ignored flag", cap_flag, 1'b0);
    drive_pin(1'b0);
    check("R2 fall value", cap_val, 16'h0A0A);
    check("R2 fall flag", cap_flag, 1'b1);
  endtask

  task automatic t_src_flag_overwrite();
    set_mode(4'b0000);
    set_mode(4'b0101);
    clear_flag();
    src_sel = 1'b1;
    timer_b = 16'hBEEF;
    pulse();
    check("R6 timer_b", cap_val, 16'hBEEF);
    repeat (5) @(negedge clk);
    check("R7 flag holds", cap_flag, 1'b1);
    clear_flag();
    check("R7 flag cleared", cap_flag, 1'b0);
    src_sel = 1'b0;
    timer_a = 16'h1111;
    pulse();
    check("R6 timer_a", cap_val, 16'h1111);
    timer_a = 16'h2222;
    pulse();
    check("R9 overwrite value", cap_val, 16'h2222);
    check("R9 flag", cap_flag, 1'b1);
  endtask

  task automatic t_clear_collide();
    timer_a = 16'h3C3C;
    cap_pin = 1'b1;
    repeat (2) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R8 flag after collision", cap_flag, 1'b1);
    check("R8 value after collision", cap_val, 16'h3C3C);
    drive_pin(1'b0);
  endtask

  task automatic t_div4();
    set_mode(4'b0000);
    set_mode(4'b0110);
    clear_flag();
    timer_a = 16'h4444;
    for (int i = 0; i < 3; i++) pulse();
    check("R4 edges 1-3 value", cap_val, 16'h3C3C);
    check("R4 edges 1-3 flag", cap_flag, 1'b0);
    pulse();
    check("R4 edge 4 value", cap_val, 16'h4444);
    check("R4 edge 4 flag", cap_flag, 1'b1);
  endtask

  task automatic t_div16();
    set_mode(4'b0000);
    set_mode(4'b0111);
    clear_flag();
    timer_a = 16'h1616;
    for (int i = 0; i < 15; i++) pulse();
    check("R5 edges 1-15 value", cap_val, 16'h4444);
    check("R5 edges 1-15 flag", cap_flag, 1'b0);
    pulse();
    check("R5 edge 16 value", cap_val, 16'h1616);
  endtask

  task automatic t_off_clears();
    set_mode(4'b0000);
    set_mode(4'b0110);
    clear_flag();
    timer_a = 16'h0FF0;
    pulse();
    pulse();
    set_mode(4'b0000);
    pulse();
    check("R10 off no capture", cap_val, 16'h1616);
    set_mode(4'b1101);
    pulse();
    check("R10 invalid code no capture", cap_val, 16'h1616);
    check("R10 invalid code no flag", cap_flag, 1'b0);
    set_mode(4'b0110);
    for (int i = 0; i < 3; i++) pulse();
    check("R10 counter emptied", cap_val, 16'h1616);
    pulse();
    check("R10 fourth edge after off", cap_val, 16'h0FF0);
  endtask

  task automatic t_switch();
    set_mode(4'b0000);
    set_mode(4'b0111);
    clear_flag();
    timer_a = 16'h7777;
    for (int i = 0; i < 5; i++) pulse();
    check("R11 no capture yet", cap_val, 16'h0FF0);
    set_mode(4'b0110);
    check("R12 hop sets flag", cap_flag, 1'b1);
    check("R12 hop keeps value", cap_val, 16'h0FF0);
    clear_flag();
    pulse();
    check("R11 early capture value", cap_val, 16'h7777);
    check("R11 early capture flag", cap_flag, 1'b1);
    clear_flag();
    set_mode(4'b0100);
    check("R12 second hop flag", cap_flag, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_latency();
    t_fall();
    t_src_flag_overwrite();
    t_clear_collide();
    t_div4();
    t_div16();
    t_off_clears();
    t_switch();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule